// File: doc/BRIEF.md
# Audio Port Control and Status Registers

This block is the software-visible register file of a serial audio port. It sits on a plain 32-bit bus (address, write enable, write data, read enable, read data) and holds four words: a control word that drives the serial engine and clock logic, a status word with sticky FIFO error flags, a data port toward the sample path, and a read-only version word.

Every register answers at three word addresses. The base address replaces the whole word. The address four bytes above it ORs the written ones into the word. The address eight bytes above it clears the written ones. Software can therefore flip one control bit without a read-modify-write, and it can acknowledge a status flag without disturbing the other flag. The serial engine reports underflow and overflow events as single-cycle pulses. These events set the flags. A flag stays set until software writes a one to it at the status clear address. A masked interrupt output summarises the two flags. Two control bits hold the port in reset and gate its clock. While the reset bit is set, the rest of the control word is kept at zero.

Top module: `aud_csr_top`

## Requirements
- R1: Word map: control at 0x00, status at 0x10, data port at 0x20, version at 0x30. Offset +0x4 is the set alias and +0x8 is the clear alias. The following addresses are unmapped: offset +0xC of each word, any address of 0x40 or above, and any address whose two low bits are not zero. An unmapped address reads as 0 and ignores writes.
- R2: A write to the control word replaces it at the base address, ORs in the ones of the write data at the set alias, and clears the bits that are one in the write data at the clear alias. All other bits keep their value.
- R3: A read returns its data on rdata_o one cycle after re_i. A read at either alias returns the same value as a read at the base address. A read has no effect on the control word.
- R4: After reset the control word is 0xC000_0000. Bit 31 is port soft reset and bit 30 is clock gate.
- R5: Whenever control bit 31 is 1 after an update, every control bit other than 31 and 30 is 0. Writes to those bits are dropped while the soft reset stays set.
- R6: port_en_o is 1 exactly when control bits 31 and 30 are both 0. ctrl_o mirrors the control word: bit 0 run, bit 1 receive (1) or transmit (0), bit 2 slave mode, bit 25 FIFO-error interrupt enable.
- R7: Status bit 31 always reads 1. Bit 0 reads busy_i. Bit 6 is the underflow flag and bit 5 is the overflow flag. Each flag is set by a one-cycle pulse on its event input. All other status bits read 0.
- R8: A flag clears only when a one is written to its bit at status clear alias 0x18. Writes at 0x10 and 0x14 leave both flags unchanged. If an event and a clear of the same flag occur in the same cycle, the flag stays set.
- R9: irq_o is high exactly when control bit 25 is 1 and at least one of the two flags is set.
- R10: A write to the data port, at the base address or at either alias, updates the held transmit word (replace, OR or clear). The new word appears on tx_data_o in the next cycle, and tx_push_o is high for that one cycle only.
- R11: A read of the data port returns the value rx_data_i had in the read cycle. rx_pop_o is high during that read cycle only.
- R12: The version word reads the VERSION parameter at any of its three addresses. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, one cycle after re_i |
| busy_i | input | 1 | Serial engine busy |
| underflow_evt_i | input | 1 | FIFO underflow event pulse |
| overflow_evt_i | input | 1 | FIFO overflow event pulse |
| rx_data_i | input | 32 | Received sample word |
| rx_pop_o | output | 1 | Receive word consumed |
| tx_data_o | output | 32 | Held transmit word |
| tx_push_o | output | 1 | Transmit word updated |
| ctrl_o | output | 32 | Control word |
| port_en_o | output | 1 | Port out of reset and ungated |
| irq_o | output | 1 | FIFO error interrupt |

## Verification
The bench attacks the soft-reset mask in two ways. First, it sets lower control bits while the reset bit is held. A design that did not mask them would let run or slave mode reach the engine during reset. Second, it sets the reset bit again later, and a leaky mask would keep the stale fields. The bench also writes to the status word at its base and set addresses, and then starts an event in the same cycle that the flag is cleared. A design with the wrong priority would lose an error, or would let software raise a flag. It also covers these cases: alias reads, partial clears on the data port, the reserved +0xC slot, misaligned addresses, and the irq mask gating a flag that is still set. A wrong decode of any of these would corrupt the control word or return stale data.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_VER  = 2'd3;

  localparam int unsigned CTRL_SRST_BIT = 31;
  localparam int unsigned CTRL_GATE_BIT = 30;
  localparam int unsigned CTRL_ERRIE_BIT = 25;
  localparam logic [DATA_W-1:0] CTRL_RST_VAL = 32'hC000_0000;
  localparam logic [DATA_W-1:0] CTRL_SRST_KEEP = 32'hC000_0000;

  localparam int unsigned STAT_PRESENT_BIT = 31;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned NUM_FLAGS = 2;
  // flag 0: underflow, flag 1: overflow
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{6, 5};

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RSVD = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] apply_op(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] wd,
                                                 input alias_op_e op);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/aud_csr_decode.sv
module aud_csr_decode
  import aud_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [1:0]        sel_o,
  output alias_op_e         op_o
);
  localparam int unsigned HI_LSB = 6;

  logic hi_zero;

  generate
    if (ADDR_W > HI_LSB) begin : g_hi
      assign hi_zero = ~|addr_i[ADDR_W-1:HI_LSB];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign op_o  = alias_op_e'(addr_i[3:2]);
  assign sel_o = addr_i[5:4];
  assign hit_o = hi_zero && (addr_i[1:0] == 2'b00) && (op_o != OP_RSVD);
endmodule

// File: rtl/aud_csr_ctrl.sv
module aud_csr_ctrl
  import aud_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, upd;

  always_comb begin
    upd = wr_i ? apply_op(ctrl_q, wdata_i, op_i) : ctrl_q;
    // soft reset pins every other field at its reset value
    ctrl_d = upd[CTRL_SRST_BIT] ? (upd & CTRL_SRST_KEEP) : upd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST_VAL;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/aud_csr_stat.sv
module aud_csr_stat
  import aud_csr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_wr_i,
  input  logic [NUM_FLAGS-1:0] clr_bits_i,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 busy_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [DATA_W-1:0]    stat_o
);
  logic [NUM_FLAGS-1:0] flag_q;

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          flag_q[i] <= 1'b0;
        else if (evt_i[i])                    flag_q[i] <= 1'b1; // event wins
        else if (clr_wr_i && clr_bits_i[i])   flag_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    stat_o = '0;
    stat_o[STAT_PRESENT_BIT] = 1'b1;
    stat_o[STAT_BUSY_BIT]    = busy_i;
    for (int i = 0; i < NUM_FLAGS; i++) stat_o[FLAG_POS[i]] = flag_q[i];
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/aud_csr_data.sv
module aud_csr_data
  import aud_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_push_o
);
  logic [DATA_W-1:0] word_q;
  logic              push_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= wr_i;
      if (wr_i) word_q <= apply_op(word_q, wdata_i, op_i);
    end
  end

  assign tx_data_o = word_q;
  assign tx_push_o = push_q;
endmodule

// File: rtl/aud_csr_top.sv
module aud_csr_top
  import aud_csr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h0003_0102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              underflow_evt_i,
  input  logic              overflow_evt_i,
  input  logic [31:0]       rx_data_i,
  output logic              rx_pop_o,
  output logic [31:0]       tx_data_o,
  output logic              tx_push_o,
  output logic [31:0]       ctrl_o,
  output logic              port_en_o,
  output logic              irq_o
);
  logic                 hit;
  logic [1:0]           sel;
  alias_op_e            op;
  logic                 wr_ctrl, wr_stat_clr, wr_data;
  logic [NUM_FLAGS-1:0] clr_bits, evts, flags;
  logic [DATA_W-1:0]    ctrl_w, stat_w, rd_mux;
  logic [DATA_W-1:0]    rdata_q;

  aud_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .sel_o  (sel),
    .op_o   (op)
  );

  assign wr_ctrl     = we_i && hit && (sel == SEL_CTRL);
  assign wr_stat_clr = we_i && hit && (sel == SEL_STAT) && (op == OP_CLR);
  assign wr_data     = we_i && hit && (sel == SEL_DATA);

  assign evts[0] = underflow_evt_i;
  assign evts[1] = overflow_evt_i;

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
      assign clr_bits[i] = wdata_i[FLAG_POS[i]];
    end
  endgenerate

  aud_csr_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .op_i    (op),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl_w)
  );

  aud_csr_stat u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_wr_i   (wr_stat_clr),
    .clr_bits_i (clr_bits),
    .evt_i      (evts),
    .busy_i     (busy_i),
    .flags_o    (flags),
    .stat_o     (stat_w)
  );

  aud_csr_data u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_data),
    .op_i      (op),
    .wdata_i   (wdata_i),
    .tx_data_o (tx_data_o),
    .tx_push_o (tx_push_o)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        SEL_CTRL: rd_mux = ctrl_w;
        SEL_STAT: rd_mux = stat_w;
        SEL_DATA: rd_mux = rx_data_i;
        default:  rd_mux = VERSION;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign rx_pop_o  = re_i && hit && (sel == SEL_DATA);
  assign ctrl_o    = ctrl_w;
  assign port_en_o = ~ctrl_w[CTRL_SRST_BIT] & ~ctrl_w[CTRL_GATE_BIT];
  assign irq_o     = ctrl_w[CTRL_ERRIE_BIT] & (|flags);
endmodule

// File: rtl/aud_csr_chk.sv
module aud_csr_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic              wd_uf_i,
  input logic              wd_of_i,
  input logic [31:0]       rdata_i,
  input logic [31:0]       ctrl_i,
  input logic              port_en_i,
  input logic              irq_i,
  input logic              tx_push_i,
  input logic              uf_i,
  input logic              of_i
);
  localparam logic [ADDR_W-1:0] A_STAT_BASE = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_STAT_CLR  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_LIMIT     = ADDR_W'(8'h40);

  logic stat_rd, data_wr, unmapped;

  assign stat_rd  = re_i && (addr_i >= A_STAT_BASE) && (addr_i <= A_STAT_CLR) && (addr_i[1:0] == 2'b00);
  assign data_wr  = we_i && (addr_i[ADDR_W-1:4] == (ADDR_W-4)'(2)) && (addr_i[3:2] != 2'b11) && (addr_i[1:0] == 2'b00);
  assign unmapped = (addr_i >= A_LIMIT) || (addr_i[1:0] != 2'b00) || (addr_i[3:2] == 2'b11);

  p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && unmapped) |=> (rdata_i == 32'h0));

  p_srst_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[31] |-> (ctrl_i[29:0] == 30'h0));

  p_port_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_i |-> (!ctrl_i[31] && !ctrl_i[30]));

  p_present_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> rdata_i[31]);

  p_uf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(uf_i) |-> $past(we_i && (addr_i == A_STAT_CLR) && wd_uf_i));

  p_of_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(of_i) |-> $past(we_i && (addr_i == A_STAT_CLR) && wd_of_i));

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ctrl_i[25] && (uf_i || of_i)));

  p_push_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_i |-> $past(data_wr));
endmodule

bind aud_csr_top aud_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .wd_uf_i   (wdata_i[6]),
  .wd_of_i   (wdata_i[5]),
  .rdata_i   (rdata_o),
  .ctrl_i    (ctrl_o),
  .port_en_i (port_en_o),
  .irq_i     (irq_o),
  .tx_push_i (tx_push_o),
  .uf_i      (flags[0]),
  .of_i      (flags[1])
);

// File: tb/aud_csr_top_tb.sv
`timescale 1ns/1ps
module aud_csr_top_tb;
  localparam int unsigned AW = 8;
  localparam logic [31:0] VER = 32'h0003_0102;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic          re = 1'b0;
  logic [31:0]   rdata;
  logic          busy = 1'b0;
  logic          uf_evt = 1'b0;
  logic          of_evt = 1'b0;
  logic [31:0]   rx_data = '0;
  logic          rx_pop;
  logic [31:0]   tx_data;
  logic          tx_push;
  logic [31:0]   ctrl;
  logic          port_en;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        re_q = 1'b0;

  always #2 clk = ~clk;

  aud_csr_top #(.ADDR_W(AW), .VERSION(VER)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .busy_i(busy), .underflow_evt_i(uf_evt),
    .overflow_evt_i(of_evt), .rx_data_i(rx_data), .rx_pop_o(rx_pop),
    .tx_data_o(tx_data), .tx_push_o(tx_push), .ctrl_o(ctrl),
    .port_en_o(port_en), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) re_q <= re;

  // monitor: compares read data one cycle after the read
  always @(negedge clk) begin
    if (re_q && rst_n) begin
      if (exp_q.size() == 0) check("R3 unexpected read", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] exp,
                        input logic exp_pop, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    #1 check({tag, " pop"}, {31'h0, rx_pop}, {31'h0, exp_pop});
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset ctrl", ctrl, 32'hC000_0000);
    check("R6 reset port_en", {31'h0, port_en}, 32'h0);
    check("R9 reset irq", {31'h0, irq}, 32'h0);
    bus_rd(8'h00, 32'hC000_0000, 1'b0, "R4 ctrl read");
    bus_rd(8'h10, 32'h8000_0000, 1'b0, "R7 status reset");
    bus_rd(8'h30, VER, 1'b0, "R12 version");

    bus_wr(8'h04, 32'h0200_0007);
    check("R5 masked while srst", ctrl, 32'hC000_0000);
    bus_wr(8'h08, 32'hC000_0000);
    check("R2 clr srst/gate", ctrl, 32'h0);
    check("R6 port_en on", {31'h0, port_en}, 32'h1);
    bus_wr(8'h04, 32'h0200_0003);
    check("R2 set alias", ctrl, 32'h0200_0003);
    bus_wr(8'h08, 32'h0000_0001);
    check("R2 clr alias", ctrl, 32'h0200_0002);
    bus_rd(8'h04, 32'h0200_0002, 1'b0, "R3 set-alias read");
    bus_rd(8'h08, 32'h0200_0002, 1'b0, "R3 clr-alias read");
    check("R3 read no side effect", ctrl, 32'h0200_0002);
    bus_wr(8'h00, 32'h0200_0004);
    check("R2 base replace", ctrl, 32'h0200_0004);

    busy = 1'b1;
    bus_rd(8'h10, 32'h8000_0001, 1'b0, "R7 busy");
    busy = 1'b0;

    @(negedge clk); uf_evt = 1'b1;
    @(negedge clk); uf_evt = 1'b0;
    check("R9 irq on underflow", {31'h0, irq}, 32'h1);
    bus_rd(8'h10, 32'h8000_0040, 1'b0, "R7 underflow sticky");
    @(negedge clk); of_evt = 1'b1;
    @(negedge clk); of_evt = 1'b0;
    bus_rd(8'h18, 32'h8000_0060, 1'b0, "R3 status alias read");

    bus_wr(8'h10, 32'h0000_0000);
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_rd(8'h10, 32'h8000_0060, 1'b0, "R8 base/set ignored");
    bus_wr(8'h18, 32'h0000_0040);
    bus_rd(8'h10, 32'h8000_0020, 1'b0, "R8 clear underflow only");

    bus_wr(8'h08, 32'h0200_0000);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    bus_wr(8'h04, 32'h0200_0000);
    check("R9 irq unmasked", {31'h0, irq}, 32'h1);

    @(negedge clk);
    of_evt = 1'b1; addr = 8'h18; wdata = 32'h0000_0020; we = 1'b1;
    @(negedge clk);
    of_evt = 1'b0; we = 1'b0;
    bus_rd(8'h10, 32'h8000_0020, 1'b0, "R8 event beats clear");
    bus_wr(8'h18, 32'h0000_0060);
    bus_rd(8'h10, 32'h8000_0000, 1'b0, "R8 both cleared");
    check("R9 irq low after clear", {31'h0, irq}, 32'h0);

    bus_wr(8'h20, 32'hA5A5_0000);
    check("R10 tx word", tx_data, 32'hA5A5_0000);
    check("R10 push pulse", {31'h0, tx_push}, 32'h1);
    @(negedge clk);
    check("R10 push one cycle", {31'h0, tx_push}, 32'h0);
    bus_wr(8'h24, 32'h0000_5A5A);
    check("R10 tx set alias", tx_data, 32'hA5A5_5A5A);
    bus_wr(8'h28, 32'hA000_000A);
    check("R10 tx clr alias", tx_data, 32'h05A5_5A50);

    rx_data = 32'h1234_5678;
    bus_rd(8'h20, 32'h1234_5678, 1'b1, "R11 rx read");
    rx_data = 32'h0BAD_F00D;
    bus_rd(8'h28, 32'h0BAD_F00D, 1'b1, "R11 rx alias read");

    bus_wr(8'h0C, 32'hFFFF_FFFF);
    check("R1 +0xC write ignored", ctrl, 32'h0200_0004);
    bus_wr(8'h01, 32'h0000_0000);
    check("R1 misaligned write ignored", ctrl, 32'h0200_0004);
    bus_wr(8'h40, 32'h0000_0000);
    check("R1 high write ignored", ctrl, 32'h0200_0004);
    bus_rd(8'h0C, 32'h0, 1'b0, "R1 +0xC read");
    bus_rd(8'h40, 32'h0, 1'b0, "R1 high read");
    bus_rd(8'h21, 32'h0, 1'b0, "R1 misaligned read");

    bus_wr(8'h30, 32'h0000_0000);
    bus_rd(8'h34, VER, 1'b0, "R12 version after write");

    bus_wr(8'h04, 32'h8000_0000);
    check("R5 srst clears fields", ctrl, 32'h8000_0000);
    check("R6 port_en off", {31'h0, port_en}, 32'h0);

    repeat (3) @(negedge clk);
    check("R3 all reads returned", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule